// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small fully associative cache of finished address translations. It sits between an address generator and a page-table walker. A lookup presents a virtual page number and the current address-space identifier. In the same cycle the block answers with either a hit, carrying the physical page, the memory-attribute index and the permission bits, or a miss, which tells the walker that a walk is needed. When the walker finishes, it writes the leaf result back through the fill port. Each fill takes the next slot in round-robin order.

An entry can cover a 4 KB page, a 64 KB run of sixteen pages formed from the contiguous hint, a 2 MB block or a 1 GB block. An entry is either global, and then matches any identifier, or tagged with the identifier given at fill time. Maintenance software drives a command port carrying a 64-bit operand. The command can flush everything, remove entries by address, or remove entries by identifier.

The lookup and fill ports are single-cycle strobes with no back-pressure. A fill is always accepted in the cycle its valid is high. A lookup always gets its answer in the cycle it is presented.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses until a fill has been made.
- R2: A lookup (`lk_valid`=1) that matches a valid entry raises `lk_hit` in the same cycle, with the stored physical page, attribute index, access bits, PXN and UXN. With no match it raises `lk_miss`. Both outputs are low while `lk_valid` is 0.
- R3: A fill with `fill_global`=0 is tagged with `fill_asid` and hits only for lookups with that identifier. A fill with `fill_global`=1 hits for any identifier.
- R4: `fill_size` encodes 0 as 4 KB, 1 as 64 KB, 2 as 2 MB and 3 as 1 GB. The tag comparison ignores VPN bits [3:0], [8:0] and [17:0] respectively. The returned physical page takes those ignored bits from the lookup VPN. The same bits of the fill VPN and fill page are discarded.
- R5: `inv_op` encodes 0 as flush all, 1 as by address, 2 as by identifier and 3 as no operation. A flush-all command clears every entry. Code 3 changes nothing.
- R6: For an invalidate by address, the identifier comes from `inv_operand[63:48]` and the VPN from `inv_operand[35:0]`. A global entry whose page covers that VPN is removed whatever its identifier. A tagged entry is removed only when its identifier also matches. Coverage is judged at each entry's own size.
- R7: For an invalidate by identifier, the identifier comes from `inv_operand[63:48]`. Every tagged entry with that identifier is removed, and global entries stay.
- R8: Fills go to slots in round-robin order. The pointer advances only on a fill, so after 16 fills the 17th evicts the oldest entry and no other.
- R9: A command in the same cycle as a lookup takes effect first, so the lookup cannot hit an entry the command removes. A fill in the same cycle as a command is written after the command and survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_vpn | input | 36 | Lookup virtual page number (VA[47:12]) |
| lk_asid | input | 16 | Current address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup missed; a walk is needed |
| lk_ppn | output | 36 | Physical page number (PA[47:12]) |
| lk_attr | output | 3 | Memory-attribute index |
| lk_ap | output | 2 | Access-permission bits |
| lk_pxn | output | 1 | Privileged execute-never |
| lk_uxn | output | 1 | Unprivileged execute-never |
| fill_valid | input | 1 | Fill strobe from the walker |
| fill_vpn | input | 36 | Virtual page number of the fill |
| fill_asid | input | 16 | Identifier of the fill |
| fill_global | input | 1 | Entry is global |
| fill_size | input | 2 | Page size code (R4) |
| fill_ppn | input | 36 | Physical page number of the fill |
| fill_attr | input | 3 | Attribute index of the fill |
| fill_ap | input | 2 | Access bits of the fill |
| fill_pxn | input | 1 | Privileged execute-never of the fill |
| fill_uxn | input | 1 | Unprivileged execute-never of the fill |
| inv_valid | input | 1 | Maintenance command strobe |
| inv_op | input | 2 | Command code (R5) |
| inv_operand | input | 64 | Command operand (R6, R7) |

## Verification
The bench targets the places where the matching rules meet.

- Large pages are probed just inside and just outside their span. A design that masked the wrong bits would either miss inside the block or hit its neighbour.
- Entries with the same page but different identifiers are invalidated one at a time. A design that ignored the identifier would drop both, or keep a global entry alive.
- Address invalidation is aimed at the interior of a 2 MB block, so a design that compared only at 4 KB granularity leaves a stale block behind.
- Invalidates are paired with a lookup and with a fill in the same cycle. A design that let the lookup see the old entry would return a translation that has already been revoked, and one that let the invalidate win over the fill would lose the new entry.
- Seventeen consecutive fills check that exactly one entry, the oldest, is evicted.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  parameter int VPN_W  = 36;
  parameter int PPN_W  = 36;
  parameter int ASID_W = 16;
  parameter int ATTR_W = 3;
  parameter int OP_W   = 64;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_2M  = 2'd2,
    PG_1G  = 2'd3
  } pg_size_e;

  typedef enum logic [1:0] {
    CMD_ALL  = 2'd0,
    CMD_VA   = 2'd1,
    CMD_ASID = 2'd2,
    CMD_NOP  = 2'd3
  } inv_cmd_e;

  typedef struct packed {
    pg_size_e            size;
    logic [PPN_W-1:0]    ppn;
    logic [ATTR_W-1:0]   attr;
    logic [1:0]          ap;
    logic                pxn;
    logic                uxn;
  } leaf_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic              glob;
    leaf_t             leaf;
  } tlb_ent_t;

  // VPN bits that a page of the given size does not compare
  function automatic logic [VPN_W-1:0] span_mask(pg_size_e s);
    logic [VPN_W-1:0] m;
    case (s)
      PG_64K:  m = VPN_W'('h0000F);
      PG_2M:   m = VPN_W'('h001FF);
      PG_1G:   m = VPN_W'('h3FFFF);
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/xlat_tlb_entry.sv
module xlat_tlb_entry
  import xlat_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  tlb_ent_t          wr_ent,
  input  logic              kill,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic [ASID_W-1:0] inv_asid,
  output logic              lk_match,
  output logic              inv_va_match,
  output logic              inv_asid_match,
  output leaf_t             leaf
);
  logic             vld;
  tlb_ent_t         ent;
  logic [VPN_W-1:0] msk;

  always_ff @(posedge clk) begin
    if (!rst_n)     vld <= 1'b0;
    else if (wr_en) vld <= 1'b1;   // fill lands after any same-cycle kill
    else if (kill)  vld <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) ent <= wr_ent;
  end

  assign msk  = span_mask(ent.leaf.size);
  assign leaf = ent.leaf;

  assign lk_match = vld && ((lk_vpn & ~msk) == ent.vpn)
                    && (ent.glob || (ent.asid == lk_asid));
  assign inv_va_match = vld && ((inv_vpn & ~msk) == ent.vpn)
                        && (ent.glob || (ent.asid == inv_asid));
  assign inv_asid_match = vld && !ent.glob && (ent.asid == inv_asid);
endmodule

// File: rtl/xlat_tlb_victim.sv
module xlat_tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (adv) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/xlat_tlb_select.sv
module xlat_tlb_select
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES-1:0]       hit_vec,
  input  leaf_t [ENTRIES-1:0]      leaves,
  output logic                     found,
  output leaf_t                    sel
);
  // lowest-numbered hit wins if entries overlap
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = leaves[i];
    end
  end
  assign found = |hit_vec;
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [ATTR_W-1:0] lk_attr,
  output logic [1:0]        lk_ap,
  output logic              lk_pxn,
  output logic              lk_uxn,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic              fill_global,
  input  logic [1:0]        fill_size,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [ATTR_W-1:0] fill_attr,
  input  logic [1:0]        fill_ap,
  input  logic              fill_pxn,
  input  logic              fill_uxn,
  input  logic              inv_valid,
  input  logic [1:0]        inv_op,
  input  logic [OP_W-1:0]   inv_operand
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0]     vic;
  logic [ENTRIES-1:0]   lk_m, va_m, as_m, kill, hit_vec;
  leaf_t [ENTRIES-1:0]  leaves;
  leaf_t                sel;
  logic                 found;
  tlb_ent_t             new_ent;
  pg_size_e             fsz;
  inv_cmd_e             cmd;
  logic [VPN_W-1:0]     inv_vpn;
  logic [ASID_W-1:0]    inv_asid;
  logic                 unused_op_bits;

  assign cmd      = inv_cmd_e'(inv_op);
  assign inv_vpn  = inv_operand[VPN_W-1:0];
  assign inv_asid = inv_operand[OP_W-1 -: ASID_W];
  assign unused_op_bits = ^inv_operand[OP_W-ASID_W-1:VPN_W];

  assign fsz                = pg_size_e'(fill_size);
  assign new_ent.vpn        = fill_vpn & ~span_mask(fsz);
  assign new_ent.asid       = fill_asid;
  assign new_ent.glob       = fill_global;
  assign new_ent.leaf.size  = fsz;
  assign new_ent.leaf.ppn   = fill_ppn & ~span_mask(fsz);
  assign new_ent.leaf.attr  = fill_attr;
  assign new_ent.leaf.ap    = fill_ap;
  assign new_ent.leaf.pxn   = fill_pxn;
  assign new_ent.leaf.uxn   = fill_uxn;

  xlat_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(fill_valid), .ptr(vic)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign kill[g] = inv_valid && ((cmd == CMD_ALL)
                     || (cmd == CMD_VA && va_m[g])
                     || (cmd == CMD_ASID && as_m[g]));

    xlat_tlb_entry u_ent (
      .clk(clk), .rst_n(rst_n),
      .wr_en(fill_valid && (vic == IDX_W'(g))),
      .wr_ent(new_ent),
      .kill(kill[g]),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .inv_vpn(inv_vpn), .inv_asid(inv_asid),
      .lk_match(lk_m[g]), .inv_va_match(va_m[g]),
      .inv_asid_match(as_m[g]),
      .leaf(leaves[g])
    );
  end

  // an entry removed this cycle is hidden from the concurrent lookup
  assign hit_vec = lk_m & ~kill;

  xlat_tlb_select #(.ENTRIES(ENTRIES)) u_sel (
    .hit_vec(hit_vec), .leaves(leaves), .found(found), .sel(sel)
  );

  assign lk_hit  = lk_valid && found;
  assign lk_miss = lk_valid && !found;
  assign lk_ppn  = sel.ppn | (lk_vpn & span_mask(sel.size));
  assign lk_attr = sel.attr;
  assign lk_ap   = sel.ap;
  assign lk_pxn  = sel.pxn;
  assign lk_uxn  = sel.uxn;
endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_valid,
  input logic       lk_hit,
  input logic       lk_miss,
  input logic       fill_valid,
  input logic       inv_valid,
  input logic [1:0] inv_op
);
  logic seen_fill;
  always_ff @(posedge clk) begin
    if (!rst_n)          seen_fill <= 1'b0;
    else if (fill_valid) seen_fill <= 1'b1;
  end

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_fill |-> !lk_hit); // R1
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss)); // R2
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_op == 2'd0 && !fill_valid) |=> !lk_hit); // R5
  AST_FLUSH_BEATS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_op == 2'd0) |-> !lk_hit); // R9
endmodule

bind xlat_tlb xlat_tlb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .lk_miss(lk_miss), .fill_valid(fill_valid), .inv_valid(inv_valid),
  .inv_op(inv_op)
);

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0; logic [35:0] lk_vpn = 0; logic [15:0] lk_asid = 0;
  logic lk_hit, lk_miss, lk_pxn, lk_uxn;
  logic [35:0] lk_ppn; logic [2:0] lk_attr; logic [1:0] lk_ap;
  logic fill_valid = 0; logic [35:0] fill_vpn = 0; logic [15:0] fill_asid = 0;
  logic fill_global = 0; logic [1:0] fill_size = 0; logic [35:0] fill_ppn = 0;
  logic [2:0] fill_attr = 0; logic [1:0] fill_ap = 0;
  logic fill_pxn = 0, fill_uxn = 0;
  logic inv_valid = 0; logic [1:0] inv_op = 0; logic [63:0] inv_operand = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlat_tlb dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill(logic [35:0] vpn, logic [15:0] asid, logic g,
                      logic [1:0] sz, logic [35:0] ppn, logic [2:0] attr = 3'd1,
                      logic [1:0] ap = 2'd0, logic pxn = 0, logic uxn = 0);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_asid = asid; fill_global = g;
    fill_size = sz; fill_ppn = ppn; fill_attr = attr; fill_ap = ap;
    fill_pxn = pxn; fill_uxn = uxn;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic inv(logic [1:0] op, logic [15:0] asid, logic [35:0] vpn);
    @(negedge clk);
    inv_valid = 1; inv_op = op; inv_operand = {asid, 12'h0, vpn};
    @(negedge clk);
    inv_valid = 0;
  endtask

  task automatic probe(logic [35:0] vpn, logic [15:0] asid);
    @(negedge clk);
    lk_valid = 1; lk_vpn = vpn; lk_asid = asid;
    #2;
  endtask

  task automatic expect_hit(string req, logic [35:0] vpn, logic [15:0] asid,
                            logic [35:0] ppn);
    probe(vpn, asid);
    check(req, lk_hit, 1);
    check(req, lk_ppn, ppn);
  endtask

  task automatic expect_miss(string req, logic [35:0] vpn, logic [15:0] asid);
    probe(vpn, asid);
    check(req, lk_hit, 0);
    check(req, lk_miss, 1);
  endtask

  task automatic t_reset;
    expect_miss("R1 empty after reset", 36'h0, 16'h0);
    expect_miss("R1 empty after reset", 36'h12345, 16'h7);
    @(negedge clk); lk_valid = 0; #2;
    check("R2 idle outputs low", {lk_hit, lk_miss}, 0);
  endtask

  task automatic t_basic;
    fill(36'h12345, 16'h1, 1, 2'd0, 36'hABCDE, 3'd5, 2'd2, 1, 0);
    probe(36'h12345, 16'h1);
    check("R2 hit", lk_hit, 1);
    check("R2 ppn", lk_ppn, 36'hABCDE);
    check("R2 attr", lk_attr, 5);
    check("R2 ap", lk_ap, 2);
    check("R2 pxn/uxn", {lk_pxn, lk_uxn}, 2'b10);
    expect_miss("R2 neighbour page misses", 36'h12346, 16'h1);
  endtask

  task automatic t_asid;
    fill(36'h200, 16'h7, 0, 2'd0, 36'h900);
    expect_hit("R3 tagged same asid", 36'h200, 16'h7, 36'h900);
    expect_miss("R3 tagged other asid", 36'h200, 16'h8);
    expect_hit("R3 global any asid", 36'h12345, 16'h99, 36'hABCDE);
  endtask

  task automatic t_sizes;
    fill(36'h3005, 16'h0, 1, 2'd1, 36'h5007);
    expect_hit("R4 64K inside", 36'h300A, 16'h0, 36'h500A);
    expect_miss("R4 64K outside", 36'h3010, 16'h0);
    fill(36'h40000, 16'h0, 1, 2'd2, 36'h80000);
    expect_hit("R4 2M inside", 36'h401FF, 16'h0, 36'h801FF);
    expect_miss("R4 2M outside", 36'h40200, 16'h0);
    fill(36'hC0000, 16'h0, 1, 2'd3, 36'h40000);
    expect_hit("R4 1G inside", 36'hC1234, 16'h0, 36'h41234);
    expect_miss("R4 1G outside", 36'h100000, 16'h0);
  endtask

  task automatic t_flush;
    fill(36'h77, 16'h2, 0, 2'd0, 36'h66);
    inv(2'd3, 16'h2, 36'h77);
    expect_hit("R5 nop keeps entry", 36'h77, 16'h2, 36'h66);
    inv(2'd0, 16'h0, 36'h0);
    expect_miss("R5 flush tagged", 36'h77, 16'h2);
    expect_miss("R5 flush global", 36'h12345, 16'h1);
    expect_miss("R5 flush block", 36'hC1234, 16'h0);
  endtask

  task automatic t_inv_va;
    fill(36'h10, 16'h1, 1, 2'd0, 36'h110);
    fill(36'h20, 16'h3, 0, 2'd0, 36'h120);
    fill(36'h20, 16'h4, 0, 2'd0, 36'h220);
    fill(36'h40000, 16'h0, 1, 2'd2, 36'h60000);
    inv(2'd1, 16'h5, 36'h10);
    expect_miss("R6 global removed any asid", 36'h10, 16'h1);
    inv(2'd1, 16'h3, 36'h20);
    expect_miss("R6 tagged match removed", 36'h20, 16'h3);
    expect_hit("R6 tagged other asid kept", 36'h20, 16'h4, 36'h220);
    inv(2'd1, 16'h9, 36'h40123);
    expect_miss("R6 block removed at own size", 36'h40000, 16'h0);
    inv(2'd0, 16'h0, 36'h0);
  endtask

  task automatic t_inv_asid;
    fill(36'h30, 16'h3, 0, 2'd0, 36'h130);
    fill(36'h31, 16'h3, 0, 2'd0, 36'h131);
    fill(36'h32, 16'h4, 0, 2'd0, 36'h132);
    fill(36'h33, 16'h3, 1, 2'd0, 36'h133);
    inv(2'd2, 16'h3, 36'h0);
    expect_miss("R7 tagged removed", 36'h30, 16'h3);
    expect_miss("R7 tagged removed", 36'h31, 16'h3);
    expect_hit("R7 other asid kept", 36'h32, 16'h4, 36'h132);
    expect_hit("R7 global kept", 36'h33, 16'h3, 36'h133);
    inv(2'd0, 16'h0, 36'h0);
  endtask

  task automatic t_round_robin;
    for (int i = 0; i < 16; i++) fill(36'h100 + 36'(i), 16'h0, 1, 2'd0, 36'h800 + 36'(i));
    expect_hit("R8 all 16 resident", 36'h100, 16'h0, 36'h800);
    expect_hit("R8 all 16 resident", 36'h10F, 16'h0, 36'h80F);
    inv(2'd3, 16'h0, 36'h0);
    fill(36'h200, 16'h0, 1, 2'd0, 36'h900);
    expect_miss("R8 oldest evicted", 36'h100, 16'h0);
    expect_hit("R8 second oldest kept", 36'h101, 16'h0, 36'h801);
    expect_hit("R8 new entry", 36'h200, 16'h0, 36'h900);
    inv(2'd0, 16'h0, 36'h0);
  endtask

  task automatic t_same_cycle;
    fill(36'h500, 16'h0, 1, 2'd0, 36'h550);
    fill(36'h501, 16'h0, 1, 2'd0, 36'h551);
    @(negedge clk);
    inv_valid = 1; inv_op = 2'd1; inv_operand = {16'h0, 12'h0, 36'h500};
    lk_valid = 1; lk_vpn = 36'h500; lk_asid = 0;
    #2;
    check("R9 lookup blind to removed entry", lk_hit, 0);
    lk_vpn = 36'h501; #1;
    check("R9 unrelated entry still hits", lk_hit, 1);
    @(negedge clk);
    inv_op = 2'd0; inv_operand = 0;
    fill_valid = 1; fill_vpn = 36'h600; fill_asid = 0; fill_global = 1;
    fill_size = 0; fill_ppn = 36'h660;
    @(negedge clk);
    inv_valid = 0; fill_valid = 0;
    expect_hit("R9 fill survives same-cycle flush", 36'h600, 16'h0, 36'h660);
    expect_miss("R9 flush removed others", 36'h501, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_asid();
    t_sizes();
    t_flush();
    t_inv_va();
    t_inv_asid();
    t_round_robin();
    t_same_cycle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule